// File: doc/BRIEF.md
# Modem Status Change Tracker

This block holds the modem-status portion of a 16550-style serial port register set. It watches two active-low modem inputs, the clear-to-send line `cts_n_i` and the data-set-ready line `dsr_n_i`. Each input is brought into the clock domain by a synchronizer. The block keeps the current level of each line and a sticky delta flag that records any change since the status byte was last read. Software reads the status byte by pulsing a read strobe. That read clears the delta flags, unless a new change lands in the same cycle.

In loopback mode the control register bits stand in for the pins. The request-to-send control bit drives the CTS path and the data-terminal-ready control bit drives the DSR path, so software can exercise the status logic without any cable. A line that is held asserted through a reset shows up as a change once reset is released. An interrupt request is raised while any delta flag is set and the external enable is high.

Top module: `mdm_stat_track`

## Requirements
- R1: While reset is held and for the first cycles after it, with both pins high, the status byte reads 0x00 and `irq_o` is 0.
- R2: A change of either polarity on `cts_n_i` sets status bit 0, and a change on `dsr_n_i` sets status bit 1. Outside loopback the flag appears after the third rising clock edge that follows the pin change (two synchronizer stages, then the detection register).
- R3: A cycle with `stat_rd_i` high clears both delta flags at that clock edge, provided no change is detected in the same cycle. The byte presented during that read still shows the flags.
- R4: If a change is detected in the same cycle as a read, the affected flag stays set.
- R5: Status bit 4 is the inverted synchronized CTS level and bit 5 is the inverted synchronized DSR level. Bits 2, 3, 6 and 7 always read 0.
- R6: When `loop_en_i` is 1, bit 0 tracks changes on `rts_ctl_i`, bit 4 equals `rts_ctl_i`, bit 1 tracks changes on `dtr_ctl_i` and bit 5 equals `dtr_ctl_i`. A loopback change is flagged one edge after it. The pins are ignored in this mode.
- R7: A modem input held low through reset sets its delta flag after reset is released. Bits 4 and 5 show the levels after two edges, and the delta flags follow after three edges.
- R8: `irq_o` is 1 exactly when `irq_en_i` is 1 and at least one delta flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_i | input | 1 | Clear-to-send modem input, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready modem input, active low, asynchronous |
| loop_en_i | input | 1 | Loopback enable (modem control register bit 4) |
| dtr_ctl_i | input | 1 | Data-terminal-ready control bit (modem control bit 0) |
| rts_ctl_i | input | 1 | Request-to-send control bit (modem control bit 1) |
| stat_rd_i | input | 1 | Status read strobe, one cycle per read |
| irq_en_i | input | 1 | Modem-status interrupt enable |
| stat_o | output | STAT_W | Status byte: bit0 CTS delta, bit1 DSR delta, bit4 CTS level, bit5 DSR level |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that `loop_en_i`, `dtr_ctl_i`, `rts_ctl_i` and `stat_rd_i` are synchronous register outputs. Only the modem pins are treated as asynchronous. The loopback property also assumes that loopback is not switched while the pin level and the control level disagree, because such a switch is itself a change. The stimulus keeps to this. It toggles loopback only while the pins are high and the control bits are low, so both sources present the same deasserted level. It drives every input on the falling clock edge.

// File: rtl/mdm_stat_pkg.sv
package mdm_stat_pkg;
   // Number of modem lines watched: index 0 is CTS, index 1 is DSR
   localparam int LINE_CNT   = 2;
   // Status byte layout: delta flags from DELTA_BASE, levels from LEVEL_BASE
   localparam int DELTA_BASE = 0;
   localparam int LEVEL_BASE = 4;
   localparam int LINE_CTS   = 0;
   localparam int LINE_DSR   = 1;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] sr_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("mdm_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= {STAGES{RST_VAL}};
      else        sr_q <= {sr_q[STAGES-2:0], din};
   end

   assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta (
   input  logic clk,
   input  logic rst_n,
   input  logic line_n,
   input  logic rd,
   output logic flag_o,
   output logic level_o
);
   logic prev_q;
   logic flag_q;
   logic chg;

   // Previous value resets to the idle (high) level, so a line held low
   // through reset looks like a change on the first sampled cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= line_n;
   end

   assign chg = (line_n != prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (chg) flag_q <= 1'b1;
      else if (rd)  flag_q <= 1'b0;
   end

   assign flag_o  = flag_q;
   assign level_o = ~line_n;

   // R3
   rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !chg) |=> !flag_q);

   // R4
   change_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> flag_q);

   // R2
   rise_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(chg));
endmodule

// File: rtl/mdm_stat_track.sv
module mdm_stat_track
   import mdm_stat_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int STAT_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cts_n_i,
   input  logic              dsr_n_i,
   input  logic              loop_en_i,
   input  logic              dtr_ctl_i,
   input  logic              rts_ctl_i,
   input  logic              stat_rd_i,
   input  logic              irq_en_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              irq_o
);
   localparam int TOP_BIT = LEVEL_BASE + LINE_CNT;

   generate
      if (STAT_W < TOP_BIT) begin : g_bad_width
         $error("mdm_stat_track: STAT_W too small for status layout");
      end
   endgenerate

   logic [LINE_CNT-1:0] pin_n;
   logic [LINE_CNT-1:0] loop_n;
   logic [LINE_CNT-1:0] sync_n;
   logic [LINE_CNT-1:0] sel_n;
   logic [LINE_CNT-1:0] delta;
   logic [LINE_CNT-1:0] level;

   assign pin_n[LINE_CTS]  = cts_n_i;
   assign pin_n[LINE_DSR]  = dsr_n_i;
   // Control bits are active high; convert to the pin polarity
   assign loop_n[LINE_CTS] = ~rts_ctl_i;
   assign loop_n[LINE_DSR] = ~dtr_ctl_i;

   for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
      mdm_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (1'b1)
      ) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (pin_n[i]),
         .dout (sync_n[i])
      );

      assign sel_n[i] = loop_en_i ? loop_n[i] : sync_n[i];

      mdm_delta u_delta (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_n (sel_n[i]),
         .rd     (stat_rd_i),
         .flag_o (delta[i]),
         .level_o(level[i])
      );
   end

   always_comb begin
      stat_o = '0;
      for (int i = 0; i < LINE_CNT; i++) begin
         stat_o[DELTA_BASE + i] = delta[i];
         stat_o[LEVEL_BASE + i] = level[i];
      end
   end

   assign irq_o = irq_en_i & (|delta);

   // R6
   loop_cts_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(delta[LINE_CTS]) && $past(loop_en_i) && $past(loop_en_i, 2))
         |-> ($past(rts_ctl_i) != $past(rts_ctl_i, 2)));

   // R8
   irq_follows_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i && stat_o[DELTA_BASE]) |-> irq_o);
endmodule

// File: tb/mdm_stat_track_bench.sv
`timescale 1ns/1ps
module mdm_stat_track_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cts_n = 1'b1, dsr_n = 1'b1;
   logic       loop_en = 1'b0, dtr = 1'b0, rts = 1'b0;
   logic       rd = 1'b0, irq_en = 1'b1;
   logic [7:0] stat;
   logic       irq;
   int         errs = 0, checks = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   mdm_stat_track u_mdm_stat_track (
      .clk(clk), .rst_n(rst_n), .cts_n_i(cts_n), .dsr_n_i(dsr_n),
      .loop_en_i(loop_en), .dtr_ctl_i(dtr), .rts_ctl_i(rts),
      .stat_rd_i(rd), .irq_en_i(irq_en), .stat_o(stat), .irq_o(irq)
   );

   // {cts_n, dsr_n, loop, dtr, rts, irq_en, rd, exp_irq, pad, exp_stat}
   localparam logic [16:0] VEC [13] = '{
      {7'b1100010, 1'b0, 1'b0, 8'h00},  // v0  idle (R5)
      {7'b0100011, 1'b1, 1'b0, 8'h11},  // v1  cts falls (R2 R8)
      {7'b0100010, 1'b0, 1'b0, 8'h10},  // v2  cleared by read (R3)
      {7'b0000011, 1'b1, 1'b0, 8'h32},  // v3  dsr falls (R2)
      {7'b1000011, 1'b1, 1'b0, 8'h21},  // v4  cts rises (R2)
      {7'b1100001, 1'b0, 1'b0, 8'h02},  // v5  irq disabled (R8)
      {7'b1100010, 1'b0, 1'b0, 8'h00},  // v6  quiet (R3)
      {7'b1110010, 1'b0, 1'b0, 8'h00},  // v7  enter loopback (R6)
      {7'b1110111, 1'b1, 1'b0, 8'h11},  // v8  rts set (R6)
      {7'b0110110, 1'b0, 1'b0, 8'h10},  // v9  cts pin ignored (R6)
      {7'b1111111, 1'b1, 1'b0, 8'h32},  // v10 dtr set (R6)
      {7'b1110011, 1'b1, 1'b0, 8'h03},  // v11 both drop (R6)
      {7'b1100010, 1'b0, 1'b0, 8'h00}   // v12 leave loopback (R6)
   };

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 stat in reset", stat, 8'h00);
      chk("R1 irq in reset", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 stat after reset", stat, 8'h00);

      for (int v = 0; v < 13; v++) begin
         {cts_n, dsr_n, loop_en, dtr, rts, irq_en} = VEC[v][16:11];
         repeat (4) @(negedge clk);
         chk($sformatf("R2/R3/R5/R6 vec%0d stat", v), stat, VEC[v][7:0]);
         chk($sformatf("R8 vec%0d irq", v), {7'b0, irq}, {7'b0, VEC[v][9]});
         if (VEC[v][10]) begin
            rd = 1'b1;
            @(negedge clk);
            rd = 1'b0;
         end
      end

      // R3: read on a quiet cycle clears both flags, byte shown during read still set
      loop_en = 1'b1; rts = 1'b1; dtr = 1'b1;
      @(negedge clk);
      chk("R6 loopback flag after one edge", stat, 8'h33);
      rd = 1'b1;
      #1 chk("R3 byte during read", stat, 8'h33);
      @(negedge clk);
      rd = 1'b0;
      chk("R3 cleared after read", stat, 8'h30);

      // R4: change coincides with read; flag must survive
      rts = 1'b0; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      chk("R4 change wins over read", stat, 8'h21);
      rd = 1'b1; rts = 1'b0; dtr = 1'b0;
      @(negedge clk);
      rd = 1'b0;
      @(negedge clk);
      chk("R4 then cleared, dtr change kept", stat, 8'h02);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0; loop_en = 1'b0;
      repeat (3) @(negedge clk);
      chk("R3 clean before reset", stat, 8'h00);

      // R7: both lines held low through reset
      cts_n = 1'b0; dsr_n = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 one edge after release", stat, 8'h00);
      @(negedge clk);
      chk("R7 R2 levels after two edges", stat, 8'h30);
      @(negedge clk);
      chk("R7 R2 deltas after three edges", stat, 8'h33);
      chk("R7 R8 irq", {7'b0, irq}, 8'h01);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule